// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves data between one narrow port (A) and a wide port made of two halves of the same width (the low half and the high half). Going from narrow to wide, two narrow words that arrive on consecutive clock edges are gathered and presented at the same time as one double-width word. The low-half path is a two-stage pipeline and the high-half path is a single register, so the first word of a pair leaves on the low half and the second on the high half, both changing on the same edge.

Going from wide to narrow, each half is captured into its own register. A select input, sampled on the clock, decides which captured half drives the narrow side. Both output enables are active low and sampled on the clock, so a change of drive direction takes effect on a clock edge. Each tri-state port is split into an input vector, an output vector and an output-valid (drive) flag, which keeps the whole block synthesizable.

All storage uses the rising clock edge. Each register group has its own active-low load strobe, and a synchronous active-low reset puts every register into a known state with all drivers off.

Top module: `bus_exchanger`

## Requirements
- R1: At a rising edge with `rst_n` low, all data registers clear to zero, the registered select goes to 0, and `a_oe`, `b_lo_oe` and `b_hi_oe` go to 0 (not driving).
- R2: Each storage register loads only at a rising edge where its own active-low strobe is 0. When the strobe is 1 it keeps its value, whatever its data input does.
- R3: The path from `a_in` to `b_lo_out` has two stages. Both stages advance only at edges with `lo_load_n` at 0, so a narrow word needs two such edges to reach `b_lo_out`.
- R4: The path from `a_in` to `b_hi_out` has one stage. A word sampled at an edge with `hi_load_n` at 0 shows on `b_hi_out` right after that edge.
- R5: A word N is sampled at edge k with `lo_load_n` at 0. A word N+1 is sampled at edge k+1 with both `lo_load_n` and `hi_load_n` at 0. After edge k+1, `b_lo_out` equals N and `b_hi_out` equals N+1.
- R6: `b_lo_in` is captured at edges with `lo_cap_n` at 0, and `b_hi_in` is captured at edges with `hi_cap_n` at 0. Each half is captured independently of the other.
- R7: The select is sampled at the rising edge. From that edge on, `a_out` shows the captured low half when the sampled value is 0 and the captured high half when it is 1. A change of `sel_hi` between edges leaves `a_out` unchanged.
- R8: After an edge where `oe_a_n` is 0, `a_oe` is 1, and after an edge where it is 1, `a_oe` is 0. `b_lo_oe` and `b_hi_oe` both follow `oe_b_n` in the same way. The two enables act independently, and changes between edges have no effect.
- R9: The data outputs always show the stored contents: `b_lo_out` and `b_hi_out` show the final narrow-to-wide registers, and `a_out` shows the selected capture, whether or not the drive flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oe_a_n | input | 1 | Narrow-side drive request, active low, registered |
| oe_b_n | input | 1 | Wide-side drive request, active low, registered |
| sel_hi | input | 1 | Half select for narrow output, registered (0 low half, 1 high half) |
| lo_load_n | input | 1 | Load strobe for the narrow-to-low-half pipeline, active low |
| hi_load_n | input | 1 | Load strobe for the narrow-to-high-half register, active low |
| lo_cap_n | input | 1 | Capture strobe for the low half toward the narrow side, active low |
| hi_cap_n | input | 1 | Capture strobe for the high half toward the narrow side, active low |
| a_in | input | W | Narrow port input data |
| a_out | output | W | Narrow port output data |
| a_oe | output | 1 | Narrow port drive flag |
| b_lo_in | input | W | Wide port low half input data |
| b_lo_out | output | W | Wide port low half output data |
| b_lo_oe | output | 1 | Wide port low half drive flag |
| b_hi_in | input | W | Wide port high half input data |
| b_hi_out | output | W | Wide port high half output data |
| b_hi_oe | output | 1 | Wide port high half drive flag |

## Verification
The bench aims at pair alignment: a design whose low-half pipeline had one stage, or whose second stage ran without the strobe, would show the second word on both halves, or lose the first word, after the pairing edge. It changes the select and the enables between edges. A combinational select or enable would then switch `a_out` or a drive flag before the clock. It also leaves single strobes low while the others stay high, which catches one half being captured or loaded under the other half's strobe, and registers that load while their strobe is inactive.

// File: rtl/bx_pkg.sv
// Shared definitions for the bus exchanger.
// Assumes: the wide port is made of exactly two halves of the narrow width.
package bx_pkg;
    localparam int HALVES = 2;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/bx_en_reg.sv
// Register with an active-low load strobe and a synchronous active-low reset.
// Assumes: rst_n and en_n are synchronous to clk.
module bx_en_reg #(
    parameter int   W       = 12,
    parameter logic RST_BIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load on strobe low, clear on reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= {W{RST_BIT}};
        else if (!en_n)
            q <= d;
    end

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> $stable(q));
    // R2
    load_when_strobed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_n |=> (q == $past(d)));
endmodule

// File: rtl/bx_a2b_path.sv
// Narrow-to-wide data path: a two-stage pipeline feeds the low half and a
// single register feeds the high half, so words sampled on consecutive
// edges leave together.
// Assumes: the second low-half stage shares the low-half load strobe.
module bx_a2b_path #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lo_load_n,
    input  logic         hi_load_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] lo_q,
    output logic [W-1:0] hi_q
);
    localparam int LO_STAGES = 2;

    logic [W-1:0] lo_pipe [LO_STAGES+1];

    assign lo_pipe[0] = a_in;

    // Low-half pipeline stages, all advancing on the same strobe.
    for (genvar s = 0; s < LO_STAGES; s++) begin : g_lo_stage
        bx_en_reg #(.W(W), .RST_BIT(1'b0)) u_stage (
            .clk  (clk),
            .rst_n(rst_n),
            .en_n (lo_load_n),
            .d    (lo_pipe[s]),
            .q    (lo_pipe[s+1])
        );
    end

    // Single high-half register.
    bx_en_reg #(.W(W), .RST_BIT(1'b0)) u_hi (
        .clk  (clk),
        .rst_n(rst_n),
        .en_n (hi_load_n),
        .d    (a_in),
        .q    (hi_q)
    );

    assign lo_q = lo_pipe[LO_STAGES];

    // R3
    lo_pipe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_load_n |=> (lo_q == $past(lo_pipe[1])));
    // R4
    hi_single_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hi_load_n |=> (hi_q == $past(a_in)));
endmodule

// File: rtl/bx_b2a_path.sv
// Wide-to-narrow data path: each half is captured into its own register, and
// a clocked select picks which capture drives the narrow side.
// Assumes: the select has no strobe and is sampled on every edge.
module bx_b2a_path #(
    parameter int W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [bx_pkg::HALVES-1:0]      cap_n,
    input  logic [bx_pkg::HALVES-1:0][W-1:0] b_in,
    input  logic                           sel_hi,
    output logic [W-1:0]                   a_data
);
    import bx_pkg::*;

    logic [HALVES-1:0][W-1:0] cap_q;
    half_e                    sel_q;

    // One capture register per wide half.
    for (genvar h = 0; h < HALVES; h++) begin : g_cap
        bx_en_reg #(.W(W), .RST_BIT(1'b0)) u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .en_n (cap_n[h]),
            .d    (b_in[h]),
            .q    (cap_q[h])
        );
    end

    // Sample the half select on every edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= HALF_LO;
        else
            sel_q <= sel_hi ? HALF_HI : HALF_LO;
    end

    // Route the selected capture to the narrow side.
    always_comb begin
        a_data = (sel_q == HALF_HI) ? cap_q[1] : cap_q[0];
    end

    // R7
    sel_lo_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_hi |=> (a_data == cap_q[0]));
    // R7
    sel_hi_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hi |=> (a_data == cap_q[1]));
endmodule

// File: rtl/bx_oe_ctl.sv
// Registered output-enable control. Requests are active low, and the drive
// flags come up disabled out of reset.
// Assumes: requests are synchronous to clk.
module bx_oe_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_a_n,
    input  logic oe_b_n,
    output logic a_drive,
    output logic b_drive
);
    logic oe_a_q;
    logic oe_b_q;

    // Sample both requests, forcing the inactive level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_a_q <= 1'b1;
            oe_b_q <= 1'b1;
        end else begin
            oe_a_q <= oe_a_n;
            oe_b_q <= oe_b_n;
        end
    end

    assign a_drive = !oe_a_q;
    assign b_drive = !oe_b_q;

    // R1
    reset_drivers_off_chk: assert property (@(posedge clk)
        !rst_n |=> (!a_drive && !b_drive));
    // R8
    a_enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_a_n |=> a_drive);
    // R8
    a_disable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_a_n |=> !a_drive);
    // R8
    b_enable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_b_n |=> b_drive);
    // R8
    b_disable_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_b_n |=> !b_drive);
endmodule

// File: rtl/bus_exchanger.sv
// Registered exchanger between one narrow port and a two-half wide port.
// Each tri-state port is split into input, output and drive-flag signals.
// Assumes: all control inputs are synchronous to clk.
module bus_exchanger #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         oe_a_n,
    input  logic         oe_b_n,
    input  logic         sel_hi,
    input  logic         lo_load_n,
    input  logic         hi_load_n,
    input  logic         lo_cap_n,
    input  logic         hi_cap_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_lo_in,
    output logic [W-1:0] b_lo_out,
    output logic         b_lo_oe,
    input  logic [W-1:0] b_hi_in,
    output logic [W-1:0] b_hi_out,
    output logic         b_hi_oe
);
    import bx_pkg::*;

    logic                     b_drive;
    logic [HALVES-1:0]        cap_n;
    logic [HALVES-1:0][W-1:0] b_in;

    assign cap_n = {hi_cap_n, lo_cap_n};
    assign b_in  = {b_hi_in, b_lo_in};

    bx_a2b_path #(.W(W)) u_a2b (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_load_n(lo_load_n),
        .hi_load_n(hi_load_n),
        .a_in     (a_in),
        .lo_q     (b_lo_out),
        .hi_q     (b_hi_out)
    );

    bx_b2a_path #(.W(W)) u_b2a (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_n (cap_n),
        .b_in  (b_in),
        .sel_hi(sel_hi),
        .a_data(a_out)
    );

    bx_oe_ctl u_oe (
        .clk    (clk),
        .rst_n  (rst_n),
        .oe_a_n (oe_a_n),
        .oe_b_n (oe_b_n),
        .a_drive(a_oe),
        .b_drive(b_drive)
    );

    assign b_lo_oe = b_drive;
    assign b_hi_oe = b_drive;

    // R1
    reset_data_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (a_out == '0 && b_lo_out == '0 && b_hi_out == '0));
    // R5
    pair_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_load_n && !hi_load_n) |=> (b_hi_out == $past(a_in)));
endmodule

// File: tb/bus_exchanger_bench.sv
`timescale 1ns/1ps
module bus_exchanger_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         oe_a_n, oe_b_n, sel_hi;
    logic         lo_load_n, hi_load_n, lo_cap_n, hi_cap_n;
    logic [W-1:0] a_in, b_lo_in, b_hi_in;
    logic [W-1:0] a_out, b_lo_out, b_hi_out;
    logic         a_oe, b_lo_oe, b_hi_oe;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    bus_exchanger #(.W(W)) u_bus_exchanger (
        .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .sel_hi(sel_hi), .lo_load_n(lo_load_n), .hi_load_n(hi_load_n),
        .lo_cap_n(lo_cap_n), .hi_cap_n(hi_cap_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_lo_in(b_lo_in), .b_lo_out(b_lo_out), .b_lo_oe(b_lo_oe),
        .b_hi_in(b_hi_in), .b_hi_out(b_hi_out), .b_hi_oe(b_hi_oe)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic strobes_idle();
        lo_load_n = 1'b1; hi_load_n = 1'b1; lo_cap_n = 1'b1; hi_cap_n = 1'b1;
    endtask

    // R1: reset state
    task automatic test_reset();
        rst_n = 1'b0; oe_a_n = 1'b0; oe_b_n = 1'b0; sel_hi = 1'b1;
        lo_load_n = 1'b0; hi_load_n = 1'b0; lo_cap_n = 1'b0; hi_cap_n = 1'b0;
        a_in = 12'hABC; b_lo_in = 12'h123; b_hi_in = 12'h456;
        tick(); tick();
        check("R1 a_oe", a_oe, 0);
        check("R1 b_lo_oe", b_lo_oe, 0);
        check("R1 b_hi_oe", b_hi_oe, 0);
        check("R1 b_lo_out", b_lo_out, 0);
        check("R1 b_hi_out", b_hi_out, 0);
        check("R1 a_out", a_out, 0);
        strobes_idle(); oe_a_n = 1'b1; oe_b_n = 1'b1; sel_hi = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    // R5: a pair of narrow words leaves aligned on both halves
    task automatic test_pair(input logic [W-1:0] w0, input logic [W-1:0] w1);
        logic [W-1:0] hi_before;
        hi_before = b_hi_out;
        a_in = w0; lo_load_n = 1'b0; hi_load_n = 1'b1;
        tick();
        check("R4 hi untouched by lo strobe", b_hi_out, hi_before);
        a_in = w1; hi_load_n = 1'b0;
        tick();
        check("R5 b_lo_out first word", b_lo_out, w0);
        check("R5 b_hi_out second word", b_hi_out, w1);
        check("R9 data shown with drivers off", {b_lo_oe, b_hi_oe}, 0);
        strobes_idle();
    endtask

    // R3/R4: stage counts; prior pair left w1 in the first low stage
    task automatic test_depth(input logic [W-1:0] prev, input logic [W-1:0] x,
                              input logic [W-1:0] y);
        a_in = x; lo_load_n = 1'b0;
        tick();
        check("R3 one edge not enough", b_lo_out, prev);
        tick();
        check("R3 two edges reach low half", b_lo_out, x);
        lo_load_n = 1'b1; a_in = y; hi_load_n = 1'b0;
        tick();
        check("R4 one edge reaches high half", b_hi_out, y);
        check("R2 low half held", b_lo_out, x);
        strobes_idle();
    endtask

    // R2: nothing loads with all strobes inactive
    task automatic test_hold();
        logic [W-1:0] lo0, hi0, a0;
        lo0 = b_lo_out; hi0 = b_hi_out; a0 = a_out;
        strobes_idle();
        a_in = ~a_in; b_lo_in = ~b_lo_in; b_hi_in = ~b_hi_in;
        tick(); tick();
        check("R2 b_lo_out held", b_lo_out, lo0);
        check("R2 b_hi_out held", b_hi_out, hi0);
        check("R2 a_out held", a_out, a0);
    endtask

    // R6/R7: captures and registered select
    task automatic test_b2a();
        b_lo_in = 12'h3A5; b_hi_in = 12'hC5A; lo_cap_n = 1'b0; hi_cap_n = 1'b0; sel_hi = 1'b0;
        tick();
        check("R7 select 0 gives low capture", a_out, 12'h3A5);
        strobes_idle(); sel_hi = 1'b1;
        tick();
        check("R7 select 1 gives high capture", a_out, 12'hC5A);
        sel_hi = 1'b0;
        #1;
        check("R7 select change between edges ignored", a_out, 12'hC5A);
        tick();
        check("R7 select 0 after edge", a_out, 12'h3A5);
        b_lo_in = 12'h0F0; b_hi_in = 12'h777; lo_cap_n = 1'b0;
        tick();
        check("R6 low half captured alone", a_out, 12'h0F0);
        lo_cap_n = 1'b1; sel_hi = 1'b1;
        tick();
        check("R6 high half not captured", a_out, 12'hC5A);
        hi_cap_n = 1'b0;
        tick();
        check("R6 high half captured", a_out, 12'h777);
        strobes_idle();
    endtask

    // R8: registered, independent enables
    task automatic test_oe();
        oe_a_n = 1'b0; oe_b_n = 1'b1;
        #1;
        check("R8 a_oe waits for edge", a_oe, 0);
        tick();
        check("R8 a_oe on", a_oe, 1);
        check("R8 b off while a on", {b_lo_oe, b_hi_oe}, 0);
        oe_a_n = 1'b1; oe_b_n = 1'b0;
        #1;
        check("R8 a_oe holds between edges", a_oe, 1);
        tick();
        check("R8 a_oe off", a_oe, 0);
        check("R8 both b halves on", {b_lo_oe, b_hi_oe}, 2'b11);
        oe_a_n = 1'b0;
        tick();
        check("R8 both sides on", {a_oe, b_lo_oe, b_hi_oe}, 3'b111);
        oe_a_n = 1'b1; oe_b_n = 1'b1;
        tick();
        check("R8 both sides off", {a_oe, b_lo_oe, b_hi_oe}, 3'b000);
    endtask

    initial begin
        test_reset();
        test_pair(12'h5A3, 12'hC3C);
        test_pair(12'hFFF, 12'h000);
        test_pair(12'h001, 12'h800);
        test_depth(12'h800, 12'h9E1, 12'h246);
        test_hold();
        test_b2a();
        test_oe();
        test_hold();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule